// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit sits in the address stage of a load/store pipeline. For each memory micro-op it takes a base register value, an index register value, a signed byte immediate, a two-bit addressing-mode code, a two-bit access-size code and a pair flag. One cycle later it presents four results:

- the effective address of the access;
- the access width in bytes;
- for paired transfers, the address of the second element;
- the new base value, with an enable, for the two indexed forms that write the base back.

The four addressing modes are:

- immediate offset;
- register offset;
- pre-index, which updates the base before the access;
- post-index, which uses the old base and then updates it.

A single adder result feeds both the access address and the write-back, so a pre-index access and its base update always agree. The memory access itself, alignment checks and address translation are handled by later stages.

Top module: `lsu_addr_gen`

## Requirements
- R1: With mode code 2'b00 (immediate offset), out_addr is in_base plus the sign-extended immediate, and out_wb_en stays low.
- R2: With mode code 2'b01 (register offset), out_addr is in_base plus in_offset, the immediate has no effect, and out_wb_en stays low.
- R3: With mode code 2'b10 (pre-index), out_addr and out_wb_value both equal in_base plus the sign-extended immediate, and out_wb_en is high.
- R4: With mode code 2'b11 (post-index), out_addr equals the unmodified in_base, out_wb_value equals in_base plus the sign-extended immediate, and out_wb_en is high.
- R5: in_imm is a two's-complement value whose top bit (bit IMM_W-1) is the sign; it is extended to 64 bits before the addition, and all sums wrap modulo 2^64.
- R6: out_size equals 2 to the power in_size. Code 0 gives 1 byte and code 3 gives 8 bytes, a doubleword.
- R7: When in_pair is high, out_addr2 equals out_addr plus out_size. When in_pair is low, out_addr2 is zero.
- R8: out_valid and all results for a micro-op appear on the clock edge that follows the cycle in which in_valid was high. Back-to-back micro-ops are accepted every cycle.
- R9: In a cycle after in_valid was low, out_valid and out_wb_en are low, and out_addr, out_addr2, out_size and out_wb_value keep their previous values.
- R10: While rst_n is low, out_valid, out_wb_en and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Micro-op present this cycle |
| in_base | input | 64 | Base register value |
| in_offset | input | 64 | Index register value (register-offset mode) |
| in_imm | input | IMM_W (12) | Signed byte immediate |
| in_mode | input | 2 | Addressing mode: 00 offset, 01 register, 10 pre-index, 11 post-index |
| in_size | input | SIZE_W (2) | Log2 of the access width in bytes |
| in_pair | input | 1 | Paired transfer of two elements |
| out_valid | output | 1 | Results valid |
| out_addr | output | 64 | Effective address of the (first) access |
| out_addr2 | output | 64 | Address of the second element, zero if not a pair |
| out_size | output | 2**SIZE_W (4) | Access width in bytes |
| out_wb_en | output | 1 | Base write-back requested |
| out_wb_value | output | 64 | New base value, zero when no write-back |

## Verification
In a pre-index or post-index pair access, three results land in the same output cycle: the access address, the second-element address and the base write-back. These cases are provoked with paired doubleword transfers, including a pre-index immediate of -16 and a post-index immediate of +16. Each such output is judged against independently computed values for all three results. The check confirms that the pre-index address equals the write-back value, that the post-index address stays on the old base, and that the pair address steps by 8. Back-to-back micro-ops of different modes are mixed with idle cycles, so that write-back enables cannot leak into a neighbouring micro-op.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  typedef enum logic [1:0] {
    AM_OFF_IMM  = 2'b00,
    AM_OFF_REG  = 2'b01,
    AM_PRE_IDX  = 2'b10,
    AM_POST_IDX = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/lsu_agu_operand.sv
module lsu_agu_operand
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [IMM_W-1:0]  imm,
  input  addr_mode_e        mode,
  output logic [ADDR_W-1:0] operand,
  output logic              wb_req,
  output logic              addr_is_sum
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_sext;

  always_comb begin
    imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
    operand  = (mode == AM_OFF_REG) ? offset : imm_sext;
    wb_req   = (mode == AM_PRE_IDX) || (mode == AM_POST_IDX);
    addr_is_sum = (mode != AM_POST_IDX);
  end
endmodule

// File: rtl/lsu_agu_adder.sv
module lsu_agu_adder #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] operand,
  input  logic              wb_req,
  input  logic              addr_is_sum,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wb_value
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum      = base + operand;
    addr     = addr_is_sum ? sum : base;
    wb_value = wb_req ? sum : '0;
  end
endmodule

// File: rtl/lsu_agu_pair.sv
module lsu_agu_pair #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 2
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SIZE_W-1:0]        size_code,
  input  logic                     pair,
  output logic [(1<<SIZE_W)-1:0]   size_bytes,
  output logic [ADDR_W-1:0]        addr2
);
  localparam int SZ_W  = 1 << SIZE_W;
  localparam int PAD_W = ADDR_W - SZ_W;

  for (genvar i = 0; i < SZ_W; i++) begin : g_size_dec
    assign size_bytes[i] = (size_code == SIZE_W'(i));
  end

  always_comb begin
    addr2 = pair ? (addr + {{PAD_W{1'b0}}, size_bytes}) : '0;
  end
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_agu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12,
  parameter int SIZE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [ADDR_W-1:0]      in_base,
  input  logic [ADDR_W-1:0]      in_offset,
  input  logic [IMM_W-1:0]       in_imm,
  input  logic [1:0]             in_mode,
  input  logic [SIZE_W-1:0]      in_size,
  input  logic                   in_pair,
  output logic                   out_valid,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [ADDR_W-1:0]      out_addr2,
  output logic [(1<<SIZE_W)-1:0] out_size,
  output logic                   out_wb_en,
  output logic [ADDR_W-1:0]      out_wb_value
);
  localparam int SZ_W = 1 << SIZE_W;

  logic [ADDR_W-1:0] operand;
  logic              wb_req;
  logic              addr_is_sum;
  logic [ADDR_W-1:0] c_addr;
  logic [ADDR_W-1:0] c_wb_value;
  logic [ADDR_W-1:0] c_addr2;
  logic [SZ_W-1:0]   c_size;

  lsu_agu_operand #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_operand (
    .offset      (in_offset),
    .imm         (in_imm),
    .mode        (addr_mode_e'(in_mode)),
    .operand     (operand),
    .wb_req      (wb_req),
    .addr_is_sum (addr_is_sum)
  );

  lsu_agu_adder #(.ADDR_W(ADDR_W)) u_adder (
    .base        (in_base),
    .operand     (operand),
    .wb_req      (wb_req),
    .addr_is_sum (addr_is_sum),
    .addr        (c_addr),
    .wb_value    (c_wb_value)
  );

  lsu_agu_pair #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_pair (
    .addr       (c_addr),
    .size_code  (in_size),
    .pair       (in_pair),
    .size_bytes (c_size),
    .addr2      (c_addr2)
  );

  // next-state
  logic              valid_d;
  logic              wb_en_d;
  logic              data_ce;

  always_comb begin
    valid_d = in_valid;
    wb_en_d = in_valid & wb_req;
    data_ce = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wb_en <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_wb_en <= wb_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr     <= '0;
      out_addr2    <= '0;
      out_size     <= '0;
      out_wb_value <= '0;
    end else if (data_ce) begin
      out_addr     <= c_addr;
      out_addr2    <= c_addr2;
      out_size     <= c_size;
      out_wb_value <= c_wb_value;
    end
  end
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 12,
  parameter int SIZE_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [ADDR_W-1:0]      in_base,
  input logic [1:0]             in_mode,
  input logic                   in_pair,
  input logic                   out_valid,
  input logic [ADDR_W-1:0]      out_addr,
  input logic [ADDR_W-1:0]      out_addr2,
  input logic [(1<<SIZE_W)-1:0] out_size,
  input logic                   out_wb_en,
  input logic [ADDR_W-1:0]      out_wb_value
);
  localparam int PAD_W = ADDR_W - (1 << SIZE_W);

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R3
  pre_idx_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10) |=> (out_wb_en && out_addr == out_wb_value));

  // R4
  post_idx_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11) |=> (out_wb_en && out_addr == $past(in_base)));

  // R1
  off_imm_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00) |=> !out_wb_en);

  // R2
  off_reg_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=> !out_wb_en);

  // R7
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pair) |=> (out_addr2 == out_addr + {{PAD_W{1'b0}}, out_size}));

  // R6
  size_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_size) && out_size != '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_wb_en && $stable(out_addr) && $stable(out_wb_value)));
endmodule

bind lsu_addr_gen lsu_agu_chk #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_base      (in_base),
  .in_mode      (in_mode),
  .in_pair      (in_pair),
  .out_valid    (out_valid),
  .out_addr     (out_addr),
  .out_addr2    (out_addr2),
  .out_size     (out_size),
  .out_wb_en    (out_wb_en),
  .out_wb_value (out_wb_value)
);

// File: tb/lsu_addr_gen_bench.sv
module lsu_addr_gen_bench;
  localparam int ADDR_W = 64;
  localparam int IMM_W  = 12;
  localparam int SIZE_W = 2;
  localparam int SZ_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [63:0]       in_base, in_offset;
  logic [IMM_W-1:0]  in_imm;
  logic [1:0]        in_mode;
  logic [SIZE_W-1:0] in_size;
  logic              in_pair;
  logic              out_valid, out_wb_en;
  logic [63:0]       out_addr, out_addr2, out_wb_value;
  logic [SZ_W-1:0]   out_size;

  always #10 clk = ~clk;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W)) u_lsu_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_base(in_base),
    .in_offset(in_offset), .in_imm(in_imm), .in_mode(in_mode), .in_size(in_size),
    .in_pair(in_pair), .out_valid(out_valid), .out_addr(out_addr),
    .out_addr2(out_addr2), .out_size(out_size), .out_wb_en(out_wb_en),
    .out_wb_value(out_wb_value)
  );

  typedef struct packed {
    logic [63:0] addr;
    logic [63:0] addr2;
    logic [63:0] wbv;
    logic        wb;
    logic [3:0]  sz;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    mon_on = 1'b0;
  bit    have_last = 1'b0;
  logic [63:0] last_addr, last_wbv;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] mode, input logic [63:0] base,
                       input logic [63:0] offs, input logic [IMM_W-1:0] imm,
                       input logic [1:0] size, input logic pair, input string tag);
    exp_t e;
    logic [63:0] sx, s_imm;
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_base = base; in_offset = offs;
    in_imm = imm; in_size = size; in_pair = pair;
    sx    = {{(64-IMM_W){imm[IMM_W-1]}}, imm};
    s_imm = base + sx;
    e.sz  = 4'(1 << size);
    case (mode)
      2'b00:   begin e.addr = s_imm;       e.wb = 1'b0; e.wbv = '0;    end
      2'b01:   begin e.addr = base + offs; e.wb = 1'b0; e.wbv = '0;    end
      2'b10:   begin e.addr = s_imm;       e.wb = 1'b1; e.wbv = s_imm; end
      default: begin e.addr = base;        e.wb = 1'b1; e.wbv = s_imm; end
    endcase
    e.addr2 = pair ? e.addr + {60'd0, e.sz} : 64'd0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_mode = 2'b10; in_base = 64'hDEAD_BEEF_0000_1111;
      in_offset = 64'h55; in_imm = 12'h7F0; in_size = 2'd1; in_pair = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 unexpected out_valid actual=1 expected=0");
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, "addr",  out_addr,       e.addr);
          chk(t, "wb_en", 64'(out_wb_en), 64'(e.wb));
          chk(t, "wbv",   out_wb_value,   e.wbv);
          chk({t, "/R7"}, "addr2", out_addr2, e.addr2);
          chk({t, "/R6"}, "size",  64'(out_size), 64'(e.sz));
          last_addr = out_addr; last_wbv = out_wb_value; have_last = 1'b1;
        end
      end else begin
        chk("R9", "wb_en idle", 64'(out_wb_en), 64'd0);
        if (have_last) begin
          chk("R9", "addr hold", out_addr, last_addr);
          chk("R9", "wbv hold",  out_wb_value, last_wbv);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_mode = 2'b00; in_base = '0; in_offset = '0;
    in_imm = '0; in_size = '0; in_pair = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "valid", 64'(out_valid), 64'd0);
    chk("R10", "wb_en", 64'(out_wb_en), 64'd0);
    chk("R10", "addr",  out_addr, 64'd0);
    chk("R10", "addr2", out_addr2, 64'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);
    // R1 positive immediate, doubleword
    drive(2'b00, 64'h1000, 64'h999, 12'h020, 2'd3, 1'b0, "R1");
    idle(1);
    // R1 / R5 negative immediate
    drive(2'b00, 64'h1000, 64'h0, 12'hFF8, 2'd3, 1'b0, "R5");
    // R5 extremes of immediate range, back to back (R8)
    drive(2'b00, 64'h1_0000, 64'h0, 12'h7FF, 2'd2, 1'b0, "R5_max");
    drive(2'b00, 64'h1_0000, 64'h0, 12'h800, 2'd2, 1'b0, "R5_min");
    // R5 wrap around zero
    drive(2'b00, 64'h4, 64'h0, 12'hFF0, 2'd0, 1'b0, "R5_wrap");
    // R2 register offset, immediate ignored
    drive(2'b01, 64'h4000, 64'hFFFF_FFFF_FFFF_FFF0, 12'h7FF, 2'd3, 1'b0, "R2");
    drive(2'b01, 64'h8000_0000, 64'h123, 12'h000, 2'd1, 1'b1, "R2_pair");
    idle(2);
    // R3 pre-index pair store with -16
    drive(2'b10, 64'h8000_0000, 64'h0, 12'hFF0, 2'd3, 1'b1, "R3");
    // R4 post-index pair with +16, back to back after write-back op
    drive(2'b11, 64'h7FFF_FFF0, 64'h0, 12'h010, 2'd3, 1'b1, "R4");
    // R1 straight after a write-back op: no leaked enable
    drive(2'b00, 64'h200, 64'h0, 12'h008, 2'd3, 1'b1, "R1_after_wb");
    idle(1);
    // R4 negative post-index, single
    drive(2'b11, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 12'hFF8, 2'd2, 1'b0, "R4_neg");
    // R3 single word pre-index
    drive(2'b10, 64'h100, 64'h0, 12'h004, 2'd2, 1'b0, "R3_word");
    // R6 every size code with pairs
    drive(2'b00, 64'h3000, 64'h0, 12'h000, 2'd0, 1'b1, "R6_b");
    drive(2'b00, 64'h3000, 64'h0, 12'h000, 2'd1, 1'b1, "R6_h");
    drive(2'b00, 64'h3000, 64'h0, 12'h000, 2'd2, 1'b1, "R6_w");
    drive(2'b00, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 12'h000, 2'd3, 1'b1, "R7_wrap");
    idle(3);
    chk("R8", "queue drained", 64'(exp_q.size()), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule